// File: doc/BRIEF.md
# SD Card Bring-Up Sequencer

This block is a hardware state machine that takes a freshly inserted SD memory card from power-on to the data-transfer state without software involvement. It does not drive the card bus itself. It asks a separate command engine to send each command by giving it a command index, a 32-bit argument and the expected response kind. The engine answers each command with either a completion (a 32-bit response word) or a timeout. CRC generation and bit-level signalling belong to the engine.

A `start` pulse begins the run at the slow identification clock. The block resets the card, probes its interface condition with an echo pattern and polls its operating condition up to a bounded number of tries. It then collects the identity, the relative card address (RCA) and the specific data. Next it asks the clock unit for the operating rate, selects the card, sets the block length when the card is standard-capacity, reads the configuration register and switches the bus to four data lines. The RCA, the capacity-status bit and the card status decoded from the address response are held on outputs. One of four outcome flags ends the run and stays set until the next `start`.

States: `ST_IDLE` goes to `ST_GO_IDLE` on start. Then the sequence runs `ST_IF_COND`, `ST_APP_OP` / `ST_OP_COND` (the loop), `ST_GET_CID`, `ST_GET_RCA`, `ST_GET_CSD`, `ST_CLK_UP` (waits for `clk_ready`) and `ST_SELECT`. `ST_SELECT` goes to `ST_BLKLEN` only for standard capacity; otherwise it goes straight to `ST_APP_SCR`. The run continues through `ST_GET_SCR`, `ST_APP_BW` and `ST_BUS_WIDTH`, and ends in `ST_READY`. There are three failure exits:
- `ST_IF_COND` goes to `ST_UNSUP` on a timeout and to `ST_UNUSABLE` on a bad echo.
- `ST_OP_COND` goes to `ST_UNUSABLE` when a voltage bit is missing, and to `ST_IO_ERR` when the tries run out.
- Any other command state goes to `ST_IO_ERR` on a timeout.

All four terminal states return to `ST_GO_IDLE` on `start`.

Top module: `sd_card_bringup`

## Requirements
- R1: After reset no command is requested, all four outcome flags and `cmd_stop` are 0 and `clk_fast` is 0 (identification rate). A `start` pulse makes the first command index 0 with argument 0 and response kind 0, issued while `clk_fast` is 0.
- R2: `cmd_valid` is a one-cycle request and is never high while `cmd_inhibit` is high. The next command is requested only after the engine has answered the previous one with `rsp_valid` or `rsp_timeout`.
- R3: The second command is index 8 with argument 0x000001AA. If it times out, the run ends with `unsupported`=1.
- R4: If bits 11:0 of the index-8 response are not 0x1AA, the run ends with `unusable`=1. Bits above 11 are ignored.
- R5: The loop sends index 55 with argument 0, then index 41 with argument 0x50FF8000. It repeats this pair until a response has bit 31 set.
- R6: An index-41 response missing any bit of the mask 0x00FF8000 ends the run with `unusable`=1.
- R7: If MAX_TRIES (default 1000) index-41 responses in a row all have bit 31 clear, the run ends with `io_error`=1 and no further command.
- R8: After the loop the order is: index 2 (argument 0), index 3 (argument 0), index 9 with the RCA in argument bits 31:16, a raise of `clk_fast` followed by a wait for `clk_ready`, then index 7 with the RCA in argument bits 31:16.
- R9: The index-41 response that ends the loop supplies bit 30, which is held on `ccs`. Index 16 with argument 512 follows index 7 only when `ccs` is 0.
- R10: The run ends with index 55 (RCA argument), index 51 (argument 0), index 55 (RCA argument) and index 6 (argument 0x2), then `ready`=1.
- R11: `rca` takes bits 31:16 of the index-3 response. `card_status` keeps bits 12:0 of that response, places bit 13 at 19, bit 14 at 22 and bit 15 at 23, and holds all other bits at 0.
- R12: A timeout on any command other than index 8 ends the run with `io_error`=1 and `cmd_stop`=1, and no further command is requested.
- R13: Response kind encoding on `cmd_rtype`: 0 none (index 0), 2 long (indices 2 and 9), 3 short with busy (index 7), 1 short for all others.
- R14: Exactly one outcome flag is high in a terminal state. It stays high until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: begin (or restart) the bring-up run |
| cmd_inhibit | input | 1 | Engine cannot accept a command |
| rsp_valid | input | 1 | Engine finished the command; `rsp_data` valid |
| rsp_timeout | input | 1 | Engine saw no response in time |
| rsp_data | input | 32 | Response word (card bits 39:8 for short responses) |
| clk_ready | input | 1 | Clock unit runs at the rate selected by `clk_fast` |
| cmd_valid | output | 1 | One-cycle command request |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rtype | output | 2 | Expected response kind |
| cmd_stop | output | 1 | Halt the engine after an I/O error |
| clk_fast | output | 1 | 0: identification rate, 1: operating rate |
| rca | output | 16 | Relative card address |
| ccs | output | 1 | Capacity status from the operating condition |
| card_status | output | 32 | Card status decoded from the address response |
| ready | output | 1 | Card in transfer state, 4-bit bus |
| unusable | output | 1 | Card rejected (echo or voltage) |
| unsupported | output | 1 | No answer to the interface probe |
| io_error | output | 1 | Timeout or poll limit reached |

## Verification
The bench attacks these corner cases, each of which a specific design fault would break:
- Echo check: it sends an echo that matches only in bits 11:0. A design that compared the full word would reject a good card.
- Capacity branch: it runs cards of both capacity classes. A wrong branch would send or omit the block-length command.
- Poll limit: it keeps the card busy for the full try budget. A counter that is off by one would issue 999 or 1001 operating-condition commands.
- Inhibit: it holds the inhibit line up after every answer. A design that ignored it would issue a command too early.
- Timeouts and voltage: a timeout in the middle of the sequence, an unanswered probe and a missing voltage bit each need their own outcome. A design that merged them would report the wrong flag, or keep talking to the card.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    localparam int IDX_W = 6;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 16;

    typedef enum logic [1:0] {
        RSP_NONE       = 2'd0,
        RSP_SHORT      = 2'd1,
        RSP_LONG       = 2'd2,
        RSP_SHORT_BUSY = 2'd3
    } rsp_kind_t;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_GO_IDLE,
        ST_IF_COND,
        ST_APP_OP,
        ST_OP_COND,
        ST_GET_CID,
        ST_GET_RCA,
        ST_GET_CSD,
        ST_CLK_UP,
        ST_SELECT,
        ST_BLKLEN,
        ST_APP_SCR,
        ST_GET_SCR,
        ST_APP_BW,
        ST_BUS_WIDTH,
        ST_READY,
        ST_UNUSABLE,
        ST_UNSUP,
        ST_IO_ERR
    } seq_state_t;

    localparam logic [IDX_W-1:0] IX_GO_IDLE = 6'd0;
    localparam logic [IDX_W-1:0] IX_CID     = 6'd2;
    localparam logic [IDX_W-1:0] IX_RCA     = 6'd3;
    localparam logic [IDX_W-1:0] IX_BUSW    = 6'd6;
    localparam logic [IDX_W-1:0] IX_SELECT  = 6'd7;
    localparam logic [IDX_W-1:0] IX_IF_COND = 6'd8;
    localparam logic [IDX_W-1:0] IX_CSD     = 6'd9;
    localparam logic [IDX_W-1:0] IX_BLKLEN  = 6'd16;
    localparam logic [IDX_W-1:0] IX_OP_COND = 6'd41;
    localparam logic [IDX_W-1:0] IX_SCR     = 6'd51;
    localparam logic [IDX_W-1:0] IX_APP     = 6'd55;

    localparam logic [WORD_W-1:0] ARG_IF_COND   = 32'h0000_01AA;
    localparam logic [WORD_W-1:0] ARG_OP_COND   = 32'h50FF_8000;
    localparam logic [WORD_W-1:0] OCR_VOLT_MASK = 32'h00FF_8000;
    localparam logic [WORD_W-1:0] ARG_BLKLEN    = 32'd512;
    localparam logic [WORD_W-1:0] ARG_BUS4      = 32'h0000_0002;

    localparam int ECHO_W       = 12;
    localparam int OCR_BUSY_BIT = 31;
    localparam int OCR_CCS_BIT  = 30;

endpackage

// File: rtl/sdb_r6_remap.sv
module sdb_r6_remap
    import sdb_pkg::*;
(
    input  logic [WORD_W-1:0] rsp_word,
    output logic [WORD_W-1:0] status_word
);
    // Low half of the address response carries compressed status bits.
    always_comb begin
        status_word        = '0;
        status_word[12:0]  = rsp_word[12:0];
        status_word[19]    = rsp_word[13];
        status_word[22]    = rsp_word[14];
        status_word[23]    = rsp_word[15];
    end
endmodule

// File: rtl/sdb_try_counter.sv
module sdb_try_counter #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    // High while the try in flight is the last one allowed.
    assign exhausted = (count == CW'(LIMIT - 1));
endmodule

// File: rtl/sdb_cmd_issuer.sv
module sdb_cmd_issuer (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic cmd_inhibit,
    input  logic rsp_valid,
    input  logic rsp_timeout,
    output logic cmd_valid,
    output logic done,
    output logic timed_out
);
    typedef enum logic [1:0] {I_IDLE, I_SEND, I_WAIT} iss_state_t;

    iss_state_t st, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= I_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt    = st;
        cmd_valid = 1'b0;
        done      = 1'b0;
        timed_out = 1'b0;
        unique case (st)
            I_IDLE: begin
                if (req) st_nxt = I_SEND;
            end
            I_SEND: begin
                if (!cmd_inhibit) begin
                    cmd_valid = 1'b1;
                    st_nxt    = I_WAIT;
                end
            end
            I_WAIT: begin
                if (rsp_timeout) begin
                    done      = 1'b1;
                    timed_out = 1'b1;
                    st_nxt    = I_IDLE;
                end else if (rsp_valid) begin
                    done   = 1'b1;
                    st_nxt = I_IDLE;
                end
            end
            default: st_nxt = I_IDLE;
        endcase
    end
endmodule

// File: rtl/sd_card_bringup.sv
module sd_card_bringup
    import sdb_pkg::*;
#(
    parameter int MAX_TRIES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_inhibit,
    input  logic              rsp_valid,
    input  logic              rsp_timeout,
    input  logic [31:0]       rsp_data,
    input  logic              clk_ready,
    output logic              cmd_valid,
    output logic [5:0]        cmd_index,
    output logic [31:0]       cmd_arg,
    output logic [1:0]        cmd_rtype,
    output logic              cmd_stop,
    output logic              clk_fast,
    output logic [15:0]       rca,
    output logic              ccs,
    output logic [31:0]       card_status,
    output logic              ready,
    output logic              unusable,
    output logic              unsupported,
    output logic              io_error
);

    seq_state_t        state, nxt;
    logic              cmd_req;
    logic              step_done;
    logic              step_tout;
    logic              tries_last;
    logic              volt_ok;
    logic              powered_up;
    logic              echo_ok;
    logic              try_clr;
    logic              try_inc;
    logic              restart;
    logic [WORD_W-1:0] status_dec;
    logic [WORD_W-1:0] rca_arg;
    rsp_kind_t         kind;

    assign volt_ok    = (rsp_data & OCR_VOLT_MASK) == OCR_VOLT_MASK;
    assign powered_up = rsp_data[OCR_BUSY_BIT];
    assign echo_ok    = rsp_data[ECHO_W-1:0] == ARG_IF_COND[ECHO_W-1:0];
    assign rca_arg    = {rca, {(WORD_W-ADDR_W){1'b0}}};
    assign restart    = start && (state == ST_IDLE || state == ST_READY ||
                                  state == ST_UNUSABLE || state == ST_UNSUP ||
                                  state == ST_IO_ERR);

    sdb_cmd_issuer u_issuer (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (cmd_req),
        .cmd_inhibit (cmd_inhibit),
        .rsp_valid   (rsp_valid),
        .rsp_timeout (rsp_timeout),
        .cmd_valid   (cmd_valid),
        .done        (step_done),
        .timed_out   (step_tout)
    );

    assign try_clr = (state == ST_IF_COND);
    assign try_inc = (state == ST_OP_COND) && step_done && !step_tout &&
                     volt_ok && !powered_up;

    sdb_try_counter #(.LIMIT(MAX_TRIES)) u_tries (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (try_clr),
        .inc       (try_inc),
        .exhausted (tries_last)
    );

    sdb_r6_remap u_remap (
        .rsp_word    (rsp_data),
        .status_word (status_dec)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = ST_GO_IDLE;
            end
            ST_GO_IDLE: begin
                if (step_done) nxt = step_tout ? ST_IO_ERR : ST_IF_COND;
            end
            ST_IF_COND: begin
                if (step_done) begin
                    if (step_tout)     nxt = ST_UNSUP;
                    else if (!echo_ok) nxt = ST_UNUSABLE;
                    else               nxt = ST_APP_OP;
                end
            end
            ST_APP_OP: begin
                if (step_done) nxt = step_tout ? ST_IO_ERR : ST_OP_COND;
            end
            ST_OP_COND: begin
                if (step_done) begin
                    if (step_tout)       nxt = ST_IO_ERR;
                    else if (!volt_ok)   nxt = ST_UNUSABLE;
                    else if (powered_up) nxt = ST_GET_CID;
                    else if (tries_last) nxt = ST_IO_ERR;
                    else                 nxt = ST_APP_OP;
                end
            end
            ST_GET_CID: begin
                if (step_done) nxt = step_tout ? ST_IO_ERR : ST_GET_RCA;
            end
            ST_GET_RCA: begin
                if (step_done) nxt = step_tout ? ST_IO_ERR : ST_GET_CSD;
            end
            ST_GET_CSD: begin
                if (step_done) nxt = step_tout ? ST_IO_ERR : ST_CLK_UP;
            end
            ST_CLK_UP: begin
                if (clk_ready) nxt = ST_SELECT;
            end
            ST_SELECT: begin
                if (step_done) begin
                    if (step_tout) nxt = ST_IO_ERR;
                    else if (ccs)  nxt = ST_APP_SCR;
                    else           nxt = ST_BLKLEN;
                end
            end
            ST_BLKLEN: begin
                if (step_done) nxt = step_tout ? ST_IO_ERR : ST_APP_SCR;
            end
            ST_APP_SCR: begin
                if (step_done) nxt = step_tout ? ST_IO_ERR : ST_GET_SCR;
            end
            ST_GET_SCR: begin
                if (step_done) nxt = step_tout ? ST_IO_ERR : ST_APP_BW;
            end
            ST_APP_BW: begin
                if (step_done) nxt = step_tout ? ST_IO_ERR : ST_BUS_WIDTH;
            end
            ST_BUS_WIDTH: begin
                if (step_done) nxt = step_tout ? ST_IO_ERR : ST_READY;
            end
            ST_READY, ST_UNUSABLE, ST_UNSUP, ST_IO_ERR: begin
                if (start) nxt = ST_GO_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        cmd_req     = 1'b1;
        cmd_index   = IX_GO_IDLE;
        cmd_arg     = '0;
        kind        = RSP_SHORT;
        ready       = 1'b0;
        unusable    = 1'b0;
        unsupported = 1'b0;
        io_error    = 1'b0;
        cmd_stop    = 1'b0;
        unique case (state)
            ST_GO_IDLE: begin
                cmd_index = IX_GO_IDLE;
                kind      = RSP_NONE;
            end
            ST_IF_COND: begin
                cmd_index = IX_IF_COND;
                cmd_arg   = ARG_IF_COND;
            end
            ST_APP_OP: begin
                cmd_index = IX_APP;
            end
            ST_OP_COND: begin
                cmd_index = IX_OP_COND;
                cmd_arg   = ARG_OP_COND;
            end
            ST_GET_CID: begin
                cmd_index = IX_CID;
                kind      = RSP_LONG;
            end
            ST_GET_RCA: begin
                cmd_index = IX_RCA;
            end
            ST_GET_CSD: begin
                cmd_index = IX_CSD;
                cmd_arg   = rca_arg;
                kind      = RSP_LONG;
            end
            ST_SELECT: begin
                cmd_index = IX_SELECT;
                cmd_arg   = rca_arg;
                kind      = RSP_SHORT_BUSY;
            end
            ST_BLKLEN: begin
                cmd_index = IX_BLKLEN;
                cmd_arg   = ARG_BLKLEN;
            end
            ST_APP_SCR, ST_APP_BW: begin
                cmd_index = IX_APP;
                cmd_arg   = rca_arg;
            end
            ST_GET_SCR: begin
                cmd_index = IX_SCR;
            end
            ST_BUS_WIDTH: begin
                cmd_index = IX_BUSW;
                cmd_arg   = ARG_BUS4;
            end
            ST_READY: begin
                cmd_req = 1'b0;
                kind    = RSP_NONE;
                ready   = 1'b1;
            end
            ST_UNUSABLE: begin
                cmd_req  = 1'b0;
                kind     = RSP_NONE;
                unusable = 1'b1;
            end
            ST_UNSUP: begin
                cmd_req     = 1'b0;
                kind        = RSP_NONE;
                unsupported = 1'b1;
            end
            ST_IO_ERR: begin
                cmd_req  = 1'b0;
                kind     = RSP_NONE;
                io_error = 1'b1;
                cmd_stop = 1'b1;
            end
            ST_IDLE, ST_CLK_UP: begin
                cmd_req = 1'b0;
                kind    = RSP_NONE;
            end
            default: begin
                cmd_req = 1'b0;
                kind    = RSP_NONE;
            end
        endcase
        cmd_rtype = kind;
    end

    // Captured card data and clock-rate request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rca         <= '0;
            ccs         <= 1'b0;
            card_status <= '0;
            clk_fast    <= 1'b0;
        end else if (restart) begin
            rca         <= '0;
            ccs         <= 1'b0;
            card_status <= '0;
            clk_fast    <= 1'b0;
        end else begin
            if (state == ST_OP_COND && step_done && !step_tout && volt_ok && powered_up) begin
                ccs <= rsp_data[OCR_CCS_BIT];
            end
            if (state == ST_GET_RCA && step_done && !step_tout) begin
                rca         <= rsp_data[WORD_W-1 -: ADDR_W];
                card_status <= status_dec;
            end
            if (state == ST_GET_CSD && step_done && !step_tout) begin
                clk_fast <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sd_card_bringup_chk.sv
module sd_card_bringup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        cmd_inhibit,
    input logic        cmd_valid,
    input logic [5:0]  cmd_index,
    input logic [31:0] cmd_arg,
    input logic        cmd_stop,
    input logic        clk_fast,
    input logic [15:0] rca,
    input logic        ccs,
    input logic        ready,
    input logic        unusable,
    input logic        unsupported,
    input logic        io_error
);
    AST_NO_ISSUE_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !cmd_inhibit); // R2

    AST_SLOW_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_index == 6'd0 || cmd_index == 6'd8 || cmd_index == 6'd41) |-> !clk_fast); // R1

    AST_RCA_IN_ARG: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_index == 6'd9 || cmd_index == 6'd7) |-> cmd_arg[31:16] == rca); // R8

    AST_FAST_BEFORE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_index == 6'd7 |-> clk_fast); // R8

    AST_BLKLEN_ONLY_SDSC: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_index == 6'd16 |-> !ccs); // R9

    AST_SILENT_ON_IOERR: assert property (@(posedge clk) disable iff (!rst_n)
        io_error |-> cmd_stop && !cmd_valid); // R12

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ready, unusable, unsupported, io_error})); // R14

    AST_OUTCOME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !start |=> ready); // R14
endmodule

bind sd_card_bringup sd_card_bringup_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cmd_inhibit (cmd_inhibit),
    .cmd_valid   (cmd_valid),
    .cmd_index   (cmd_index),
    .cmd_arg     (cmd_arg),
    .cmd_stop    (cmd_stop),
    .clk_fast    (clk_fast),
    .rca         (rca),
    .ccs         (ccs),
    .ready       (ready),
    .unusable    (unusable),
    .unsupported (unsupported),
    .io_error    (io_error)
);

// File: tb/sim_sd_card_bringup.sv
`timescale 1ns/1ps
module sim_sd_card_bringup;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmd_inhibit = 1'b0;
    logic        rsp_valid = 1'b0;
    logic        rsp_timeout = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        clk_ready = 1'b0;
    logic        cmd_valid;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic [1:0]  cmd_rtype;
    logic        cmd_stop;
    logic        clk_fast;
    logic [15:0] rca;
    logic        ccs;
    logic [31:0] card_status;
    logic        ready, unusable, unsupported, io_error;

    int compared = 0;
    int mismatched = 0;

    // Scenario knobs for the card model
    int          sc_to_idx = -1;
    logic [31:0] sc_echo = 32'h1AA;
    int          sc_busy = 0;
    logic        sc_ccs = 1'b0;
    logic        sc_volt_bad = 1'b0;
    logic [31:0] sc_rca_word = '0;
    logic        sc_inhibit = 1'b0;

    // Card model state
    int       acmd_seen = 0;
    int       pend_cnt = 0;
    int       pend_idx = 0;
    int       inh_cnt = 0;
    logic     got_cmd = 1'b0;
    int       got_idx = 0;
    logic [2:0] clk_sh = '0;

    logic [39:0] exp_q[$];

    always #4 clk = ~clk; // 125 MHz

    sd_card_bringup u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_inhibit(cmd_inhibit),
        .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_data(rsp_data),
        .clk_ready(clk_ready), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .cmd_rtype(cmd_rtype), .cmd_stop(cmd_stop),
        .clk_fast(clk_fast), .rca(rca), .ccs(ccs), .card_status(card_status),
        .ready(ready), .unusable(unusable), .unsupported(unsupported),
        .io_error(io_error)
    );

    function automatic string req_tag(int idx);
        case (idx)
            0:       return "R1";
            8:       return "R3";
            55, 41:  return "R5";
            2, 3, 9, 7: return "R8";
            16:      return "R9";
            default: return "R10";
        endcase
    endfunction

    // Driver side of the scoreboard
    task automatic push_cmd(int idx, logic [31:0] arg, logic [1:0] rt);
        exp_q.push_back({idx[5:0], arg, rt});
    endtask

    task automatic push_tries(int n);
        for (int i = 0; i < n; i++) begin
            push_cmd(55, 32'h0, 2'd1);
            push_cmd(41, 32'h50FF8000, 2'd1);
        end
    endtask

    task automatic push_tail(logic [15:0] r, logic c);
        push_cmd(2, 32'h0, 2'd2);
        push_cmd(3, 32'h0, 2'd1);
        push_cmd(9, {r, 16'h0}, 2'd2);
        push_cmd(7, {r, 16'h0}, 2'd3);
        if (!c) push_cmd(16, 32'd512, 2'd1);
        push_cmd(55, {r, 16'h0}, 2'd1);
        push_cmd(51, 32'h0, 2'd1);
        push_cmd(55, {r, 16'h0}, 2'd1);
        push_cmd(6, 32'h2, 2'd1);
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] expv);
        compared++;
        if (got !== expv) begin
            mismatched++;
            $display("FAIL %s got %h exp %h", tag, got, expv);
        end
    endtask

    // Monitor: pops expected commands as the design issues them
    initial forever begin
        @(negedge clk);
        if (rst_n && cmd_valid) begin
            compared++;
            if (cmd_inhibit) begin
                mismatched++;
                $display("FAIL R2 command %0d under inhibit got inhibit=1 exp 0", cmd_index);
            end
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL R12 extra command got idx=%0d arg=%h exp none", cmd_index, cmd_arg);
            end else begin
                logic [39:0] e;
                logic [39:0] g;
                e = exp_q.pop_front();
                g = {cmd_index, cmd_arg, cmd_rtype};
                if (g !== e) begin
                    mismatched++;
                    $display("FAIL %s/R13 command got %h exp %h", req_tag(int'(e[39:34])), g, e);
                end
            end
        end
    end

    // Card model: notes each request mid-cycle
    initial forever begin
        @(negedge clk);
        if (rst_n && cmd_valid) begin
            got_cmd = 1'b1;
            got_idx = int'(cmd_index);
        end
    end

    // Card model: answers a few cycles later, drives inputs after the edge
    initial forever begin
        @(posedge clk);
        #2;
        rsp_valid = 1'b0;
        rsp_timeout = 1'b0;
        clk_sh = {clk_sh[1:0], clk_fast};
        clk_ready = clk_sh[2];
        if (inh_cnt > 0) begin
            inh_cnt--;
            if (inh_cnt == 0) cmd_inhibit = 1'b0;
        end
        if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
                if (pend_idx == sc_to_idx) begin
                    rsp_timeout = 1'b1;
                end else begin
                    rsp_valid = 1'b1;
                    case (pend_idx)
                        8:  rsp_data = sc_echo;
                        41: begin
                            if (sc_volt_bad) rsp_data = 32'h00FF0000;
                            else if (acmd_seen < sc_busy) rsp_data = 32'h00FF8000;
                            else rsp_data = 32'h80FF8000 | (sc_ccs ? 32'h40000000 : 32'h0);
                            acmd_seen++;
                        end
                        3:  rsp_data = sc_rca_word;
                        default: rsp_data = 32'h00000900;
                    endcase
                end
                if (sc_inhibit) begin
                    cmd_inhibit = 1'b1;
                    inh_cnt = 5;
                end
            end
        end
        if (got_cmd) begin
            got_cmd = 1'b0;
            pend_idx = got_idx;
            pend_cnt = 3;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        acmd_seen = 0;
        pend_cnt = 0;
        got_cmd = 1'b0;
        inh_cnt = 0;
        cmd_inhibit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_outcome(int max_cycles);
        int n = 0;
        while (!(ready || unusable || unsupported || io_error) && n < max_cycles) begin
            @(negedge clk);
            n++;
        end
        if (n >= max_cycles) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog no outcome got none exp outcome");
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic set_card(int to_idx, logic [31:0] echo, int busy, logic c,
                            logic vbad, logic [31:0] rword, logic inh);
        sc_to_idx = to_idx;
        sc_echo = echo;
        sc_busy = busy;
        sc_ccs = c;
        sc_volt_bad = vbad;
        sc_rca_word = rword;
        sc_inhibit = inh;
    endtask

    initial begin
        // Reset state (R1)
        set_card(-1, 32'h1AA, 0, 1'b0, 1'b0, 32'h0, 1'b0);
        do_reset();
        chk("R1 outcome flags after reset", {28'h0, ready, unusable, unsupported, io_error}, 32'h0);
        chk("R1 request/stop/clk after reset", {29'h0, cmd_valid, cmd_stop, clk_fast}, 32'h0);

        // Standard-capacity card, busy twice, inhibit held after each answer
        set_card(-1, 32'h1AA, 2, 1'b0, 1'b0, 32'h1234E5A7, 1'b1);
        do_reset();
        push_cmd(0, 32'h0, 2'd0);
        push_cmd(8, 32'h1AA, 2'd1);
        push_tries(3);
        push_tail(16'h1234, 1'b0);
        pulse_start();
        wait_outcome(5000);
        chk("R10 ready outcome", {28'h0, ready, unusable, unsupported, io_error}, 32'h8);
        chk("R10 all commands seen", exp_q.size(), 0);
        chk("R11 rca", {16'h0, rca}, 32'h1234);
        chk("R11 card status remap", card_status, 32'h00C805A7);
        chk("R9 capacity bit low", {31'h0, ccs}, 32'h0);
        chk("R8 operating clock", {31'h0, clk_fast}, 32'h1);

        // High-capacity card, upper echo bits differ, ready on first try
        set_card(-1, 32'h0000F1AA, 0, 1'b1, 1'b0, 32'hBEEF1FFF, 1'b0);
        do_reset();
        push_cmd(0, 32'h0, 2'd0);
        push_cmd(8, 32'h1AA, 2'd1);
        push_tries(1);
        push_tail(16'hBEEF, 1'b1);
        pulse_start();
        wait_outcome(5000);
        chk("R4 upper echo bits ignored, ready", {28'h0, ready, unusable, unsupported, io_error}, 32'h8);
        chk("R9 no block length for high capacity", exp_q.size(), 0);
        chk("R9 capacity bit high", {31'h0, ccs}, 32'h1);
        chk("R11 rca second card", {16'h0, rca}, 32'hBEEF);
        chk("R11 card status low bits only", card_status, 32'h00001FFF);
        repeat (20) @(negedge clk);
        chk("R14 ready held", {28'h0, ready, unusable, unsupported, io_error}, 32'h8);

        // Probe timeout
        set_card(8, 32'h1AA, 0, 1'b0, 1'b0, 32'h0, 1'b0);
        do_reset();
        push_cmd(0, 32'h0, 2'd0);
        push_cmd(8, 32'h1AA, 2'd1);
        pulse_start();
        wait_outcome(2000);
        chk("R3 unsupported on probe timeout", {28'h0, ready, unusable, unsupported, io_error}, 32'h2);
        chk("R3 no command after probe", exp_q.size(), 0);
        chk("R3 engine not stopped", {31'h0, cmd_stop}, 32'h0);

        // Bad echo
        set_card(-1, 32'h2AA, 0, 1'b0, 1'b0, 32'h0, 1'b0);
        do_reset();
        push_cmd(0, 32'h0, 2'd0);
        push_cmd(8, 32'h1AA, 2'd1);
        pulse_start();
        wait_outcome(2000);
        chk("R4 unusable on bad echo", {28'h0, ready, unusable, unsupported, io_error}, 32'h4);
        chk("R4 sequence stopped", exp_q.size(), 0);

        // Missing voltage window bit
        set_card(-1, 32'h1AA, 0, 1'b0, 1'b1, 32'h0, 1'b0);
        do_reset();
        push_cmd(0, 32'h0, 2'd0);
        push_cmd(8, 32'h1AA, 2'd1);
        push_tries(1);
        pulse_start();
        wait_outcome(2000);
        chk("R6 unusable on voltage", {28'h0, ready, unusable, unsupported, io_error}, 32'h4);
        chk("R6 sequence stopped", exp_q.size(), 0);

        // Timeout in the middle of the sequence
        set_card(2, 32'h1AA, 0, 1'b0, 1'b0, 32'h0, 1'b0);
        do_reset();
        push_cmd(0, 32'h0, 2'd0);
        push_cmd(8, 32'h1AA, 2'd1);
        push_tries(1);
        push_cmd(2, 32'h0, 2'd2);
        pulse_start();
        wait_outcome(2000);
        chk("R12 io error on timeout", {28'h0, ready, unusable, unsupported, io_error}, 32'h1);
        chk("R12 engine stopped", {31'h0, cmd_stop}, 32'h1);
        chk("R12 no command after timeout", exp_q.size(), 0);

        // Card never powers up: full try budget
        set_card(-1, 32'h1AA, 1000000, 1'b0, 1'b0, 32'h0, 1'b0);
        do_reset();
        push_cmd(0, 32'h0, 2'd0);
        push_cmd(8, 32'h1AA, 2'd1);
        push_tries(1000);
        pulse_start();
        wait_outcome(60000);
        chk("R7 io error after try limit", {28'h0, ready, unusable, unsupported, io_error}, 32'h1);
        chk("R7 exactly limit tries issued", exp_q.size(), 0);
        chk("R7 poll responses counted", acmd_seen, 1000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Global watchdog
    initial begin
        repeat (190000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog run hung got running exp finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule